// File: doc/BRIEF.md
# 128b/130b Receive Gearbox

This block sits between a deserialiser and the link layer of a 128b/130b receive lane. It accepts 32 serial bits per cycle. The first-received bit is on input bit 0. The block locates 130-bit block boundaries and removes each block's 2-bit sync header. It passes the 128-bit payload downstream as four 32-bit words. Payload bytes come out little endian: the first byte received is on bits [7:0].

A 130-bit block takes more than four 32-bit input words, so the spare header bits build up over time. Every 65 input cycles (16 blocks) there is one cycle in which no complete word is ready. In that cycle the word-valid qualifier drops and the consumer ignores the data. There is no backpressure, and words leave as soon as their bits have arrived.

Alignment has two sources:
- After reset, the parameter `START_OFS` gives the bit position of the first block start in the first input word.
- At any later time, a one-cycle `align_load` pulse flushes the bit buffer. Bit `slip_ofs` of the word presented in that cycle then becomes the first header bit of a new block.

Top module: `gb130_rx`

## Requirements
- R1: Payload bits leave in arrival order. The first payload bit of a word appears on `word_out[0]`, so the first byte received sits on bits [7:0] and the fourth on bits [31:24]. Every payload word of every block is delivered exactly once and in order.
- R2: `blk_start` is 4'b0001 in the output cycle carrying word 0 of a block, and 4'b0000 in every other cycle.
- R3: In a `blk_start` = 4'b0001 cycle, `sync_hdr` is {second header bit, first header bit}. 2'b10 marks a data block and 2'b01 an ordered-set block.
- R4: For a continuous aligned stream, exactly 64 of any 65 consecutive output cycles starting from reset have `word_valid` = 1. In a cycle with `word_valid` = 0, `blk_start` and `hdr_err` are 0.
- R5: In valid cycles, `ctl_flags` is 4'b1111 for every word of an ordered-set block and 4'b0000 for every word of a data block or a block with an illegal header.
- R6: A block whose header is 2'b00 or 2'b11 drives `lane_valid` = 0 on all four of its words and pulses `hdr_err` on its first word. Legal blocks drive `lane_valid` = 1.
- R7: While `rst_n` is low, `word_valid`, `lane_valid`, `blk_start`, `hdr_err` and `ctl_flags` are all 0. After release, the first `START_OFS` bits of the first input word are discarded.
- R8: With `align_load` high, the bit buffer is cleared and input bits below `slip_ofs` of that word are discarded. The next block header starts at bit `slip_ofs`.
- R9: The output is registered with zero ready latency. With offset 0 from reset, the cycle after the first input edge has `word_valid` = 0 (34 bits are not yet present), and the next has `word_valid` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_bits | input | 32 | Deserialised bits, bit 0 received first |
| align_load | input | 1 | Realign pulse: flush buffer and restart at `slip_ofs` |
| slip_ofs | input | 5 | Bit position of the block start in the current word |
| word_out | output | 32 | Payload word, little endian |
| ctl_flags | output | 4 | Per-byte control flags, bit 0 for byte 0 |
| blk_start | output | 4 | Block-start byte marker, 4'b0001 on word 0 |
| sync_hdr | output | 2 | Sync header of the current block |
| word_valid | output | 1 | Word qualifier, low in rate-matching cycles |
| lane_valid | output | 1 | Block has a legal header |
| hdr_err | output | 1 | Illegal header pulse on first word |

## Verification
The bench targets the following corner cases:
- **Rate matching.** It counts valid cycles over a full 16-block period. A gearbox that never stalls would emit stale or shifted words. One that stalls too often would fall behind the 32-bit input and lose the count of 64.
- **Illegal headers.** It embeds 2'b00 and 2'b11 headers between legal blocks. A design that latched the error status wrongly would either leak `lane_valid` into the bad block or carry the error into the next block.
- **Realignment.** It realigns both at reset-release and in the middle of a garbage stream. A design that kept old buffered bits across `align_load` would shift every later word.
- **Byte order.** It checks every payload word by value, so a byte swap or an off-by-two header strip fails at once.

// File: rtl/gb130_pkg.sv
package gb130_pkg;
    localparam int DATA_W    = 32;
    localparam int HDR_W     = 2;
    localparam int PAY_W     = 128;
    localparam int BYTES     = DATA_W / 8;
    localparam int BLK_WORDS = PAY_W / DATA_W;
    localparam int PH_W      = $clog2(BLK_WORDS);
    localparam int BUF_W     = 3 * DATA_W;
    localparam int CNT_W     = $clog2(BUF_W + 1);
    localparam int SKIP_W    = $clog2(DATA_W);

    typedef struct packed {
        logic [BUF_W-1:0]  bits;
        logic [CNT_W-1:0]  cnt;
        logic [PH_W-1:0]   ph;
        logic              first;
        logic              blk_os;
        logic              blk_bad;
        logic [DATA_W-1:0] word;
        logic [BYTES-1:0]  k;
        logic [BYTES-1:0]  start;
        logic [HDR_W-1:0]  hdr;
        logic              wv;
        logic              lv;
        logic              err;
    } gb_state_t;
endpackage

// File: rtl/gb130_merge.sv
module gb130_merge #(
    parameter int DW = 32,
    parameter int BW = 96,
    parameter int CW = 7,
    parameter int SW = 5
) (
    input  logic [BW-1:0] bits_in,
    input  logic [CW-1:0] cnt_in,
    input  logic [DW-1:0] din,
    input  logic [SW-1:0] skip,
    output logic [BW-1:0] bits_out,
    output logic [CW-1:0] cnt_out
);
    logic [BW-1:0] shifted;

    // Drop the skipped low bits, then park the rest above the held bits.
    always_comb begin
        shifted  = BW'(din >> skip);
        bits_out = bits_in | (shifted << cnt_in);
        cnt_out  = cnt_in + CW'(DW) - CW'(skip);
    end
endmodule

// File: rtl/gb130_extract.sv
module gb130_extract #(
    parameter int DW = 32,
    parameter int BW = 96,
    parameter int HW = 2
) (
    input  logic [BW-1:0] merged,
    input  logic          head,
    output logic [DW-1:0] word,
    output logic [HW-1:0] hdr
);
    // The first word of a block sits above its header bits.
    always_comb begin
        word = head ? merged[HW +: DW] : merged[DW-1:0];
        hdr  = merged[HW-1:0];
    end
endmodule

// File: rtl/gb130_rx.sv
module gb130_rx
    import gb130_pkg::*;
#(
    parameter int START_OFS = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] rx_bits,
    input  logic              align_load,
    input  logic [SKIP_W-1:0] slip_ofs,
    output logic [DATA_W-1:0] word_out,
    output logic [BYTES-1:0]  ctl_flags,
    output logic [BYTES-1:0]  blk_start,
    output logic [HDR_W-1:0]  sync_hdr,
    output logic              word_valid,
    output logic              lane_valid,
    output logic              hdr_err
);
    localparam logic [HDR_W-1:0] HDR_OS   = 2'b01;
    localparam logic [HDR_W-1:0] HDR_DATA = 2'b10;
    localparam logic [CNT_W-1:0] NEED_HD  = CNT_W'(DATA_W + HDR_W);
    localparam logic [CNT_W-1:0] NEED_BD  = CNT_W'(DATA_W);

    gb_state_t s_q, s_d;

    logic [BUF_W-1:0]  base_bits_d;
    logic [CNT_W-1:0]  base_cnt_d;
    logic [PH_W-1:0]   ph_d;
    logic [SKIP_W-1:0] skip_d;
    logic [BUF_W-1:0]  merged_d;
    logic [CNT_W-1:0]  merged_cnt_d;
    logic [DATA_W-1:0] word_d;
    logic [HDR_W-1:0]  hdr_d;
    logic              head_d;

    // Realignment flushes the buffer and restarts the block phase.
    always_comb begin
        base_bits_d = align_load ? '0 : s_q.bits;
        base_cnt_d  = align_load ? '0 : s_q.cnt;
        ph_d        = align_load ? '0 : s_q.ph;
        if (align_load)   skip_d = slip_ofs;
        else if (s_q.first) skip_d = SKIP_W'(START_OFS);
        else              skip_d = '0;
        head_d = (ph_d == '0);
    end

    gb130_merge #(.DW(DATA_W), .BW(BUF_W), .CW(CNT_W), .SW(SKIP_W)) i_merge (
        .bits_in  (base_bits_d),
        .cnt_in   (base_cnt_d),
        .din      (rx_bits),
        .skip     (skip_d),
        .bits_out (merged_d),
        .cnt_out  (merged_cnt_d)
    );

    gb130_extract #(.DW(DATA_W), .BW(BUF_W), .HW(HDR_W)) i_extract (
        .merged (merged_d),
        .head   (head_d),
        .word   (word_d),
        .hdr    (hdr_d)
    );

    always_comb begin
        logic [CNT_W-1:0] need;
        logic             os, bad;
        s_d       = s_q;
        s_d.first = 1'b0;
        s_d.wv    = 1'b0;
        s_d.start = '0;
        s_d.err   = 1'b0;
        s_d.bits  = merged_d;
        s_d.cnt   = merged_cnt_d;
        s_d.ph    = ph_d;
        need      = head_d ? NEED_HD : NEED_BD;
        os        = head_d ? (hdr_d == HDR_OS) : s_q.blk_os;
        bad       = head_d ? (hdr_d != HDR_OS && hdr_d != HDR_DATA) : s_q.blk_bad;
        if (merged_cnt_d >= need) begin
            s_d.wv   = 1'b1;
            s_d.word = word_d;
            s_d.bits = merged_d >> need;
            s_d.cnt  = merged_cnt_d - need;
            s_d.ph   = ph_d + 1'b1;
            s_d.k    = {BYTES{os}};
            s_d.lv   = !bad;
            if (head_d) begin
                s_d.blk_os  = os;
                s_d.blk_bad = bad;
                s_d.start   = BYTES'(1);
                s_d.hdr     = hdr_d;
                s_d.err     = bad;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.first <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign word_out   = s_q.word;
    assign ctl_flags  = s_q.k;
    assign blk_start  = s_q.start;
    assign sync_hdr   = s_q.hdr;
    assign word_valid = s_q.wv;
    assign lane_valid = s_q.lv;
    assign hdr_err    = s_q.err;
endmodule

// File: rtl/gb130_rx_chk.sv
module gb130_rx_chk
    import gb130_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              align_load,
    input logic [BYTES-1:0]  ctl_flags,
    input logic [BYTES-1:0]  blk_start,
    input logic [HDR_W-1:0]  sync_hdr,
    input logic              word_valid,
    input logic              lane_valid,
    input logic              hdr_err
);
    logic [PH_W-1:0] seen_ph;

    // Independent count of delivered words within the current block.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          seen_ph <= '0;
        else if (align_load) seen_ph <= '0;
        else if (word_valid) seen_ph <= seen_ph + 1'b1;
    end

    p_start_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_start != '0) |-> (blk_start == BYTES'(1) && word_valid));

    p_start_phase_r2: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> ((blk_start == BYTES'(1)) == (seen_ph == '0)));

    p_hdr_class_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_start == BYTES'(1)) |-> (hdr_err == (sync_hdr == 2'b00 || sync_hdr == 2'b11)));

    p_stall_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !word_valid |-> (blk_start == '0 && !hdr_err));

    p_ctl_uniform_r5: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> (ctl_flags == '0 || ctl_flags == '1));

    p_err_lane_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_err |-> (!lane_valid && ctl_flags == '0));
endmodule

bind gb130_rx gb130_rx_chk i_chk (.*);

// File: tb/test_gb130_rx.sv
module test_gb130_rx;
    localparam int CLK_PERIOD = 10;

    // {sync header, payload seed}; header 00 at 5 and 11 at 11
    localparam logic [33:0] VEC [0:15] = '{
        {2'b10, 32'h03020100}, {2'b10, 32'hA5C3_0F11}, {2'b01, 32'h1C1C_1C1C},
        {2'b10, 32'hDEAD_BEEF}, {2'b10, 32'h0000_0001}, {2'b00, 32'h8080_7F7F},
        {2'b10, 32'hFFFF_FFFF}, {2'b01, 32'h5566_7788}, {2'b10, 32'h1234_5678},
        {2'b10, 32'h8000_0000}, {2'b01, 32'h0BAD_F00D}, {2'b11, 32'h4242_4242},
        {2'b10, 32'hC0FF_EE00}, {2'b01, 32'h7E7E_00FF}, {2'b10, 32'h3141_5926},
        {2'b10, 32'h2718_2818}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] rx_bits = '0;
    logic        align_load = 1'b0;
    logic [4:0]  slip_ofs = '0;
    logic [31:0] word_out;
    logic [3:0]  ctl_flags, blk_start;
    logic [1:0]  sync_hdr;
    logic        word_valid, lane_valid, hdr_err;

    int n_chk = 0;
    int n_fail = 0;
    logic sbits [0:4095];

    always #(CLK_PERIOD / 2) clk = ~clk;

    gb130_rx i_gb130_rx (
        .clk(clk), .rst_n(rst_n), .rx_bits(rx_bits), .align_load(align_load),
        .slip_ofs(slip_ofs), .word_out(word_out), .ctl_flags(ctl_flags),
        .blk_start(blk_start), .sync_hdr(sync_hdr), .word_valid(word_valid),
        .lane_valid(lane_valid), .hdr_err(hdr_err)
    );

    function automatic logic [31:0] pay(input int b, input int j);
        return VEC[b][31:0] + 32'(j) * 32'h0103_0507;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic build(input int pre, input int nblk, input int base);
        int p = 0;
        for (int i = 0; i < 4096; i++) sbits[i] = 1'b0;
        for (int i = 0; i < pre; i++) begin
            sbits[p] = ((i * 7) % 3 == 0);
            p++;
        end
        for (int b = 0; b < nblk; b++) begin
            sbits[p] = VEC[base + b][32]; p++;
            sbits[p] = VEC[base + b][33]; p++;
            for (int j = 0; j < 4; j++)
                for (int k = 0; k < 32; k++) begin
                    sbits[p] = pay(base + b, j)[k];
                    p++;
                end
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        align_load = 1'b0;
        rx_bits = '0;
        repeat (2) @(negedge clk);
        chk(!word_valid && !lane_valid && !hdr_err, "R7 reset flags",
            {29'b0, word_valid, lane_valid, hdr_err}, 32'h0);
        chk(blk_start == 4'h0 && ctl_flags == 4'h0, "R7 reset markers",
            {24'b0, blk_start, ctl_flags}, 32'h0);
        rst_n = 1'b1;
    endtask

    task automatic run(input int ncyc, input int al_c, input int slip,
                       input int base, input int nexp, input bit rate);
        int idx = 0;
        int nv = 0;
        for (int c = 0; c <= ncyc; c++) begin
            if (c > 0) @(negedge clk);
            if (c > 0) begin
                if (c > al_c && word_valid && idx < nexp) begin
                    int b = base + idx / 4;
                    int j = idx % 4;
                    logic [1:0] h = VEC[b][33:32];
                    bit good = (h == 2'b10 || h == 2'b01);
                    chk(word_out == pay(b, j), "R1 payload", word_out, pay(b, j));
                    chk(blk_start == ((j == 0) ? 4'b0001 : 4'b0000), "R2 block start",
                        32'(blk_start), (j == 0) ? 32'h1 : 32'h0);
                    if (j == 0)
                        chk(sync_hdr == h, "R3 sync header", 32'(sync_hdr), 32'(h));
                    chk(ctl_flags == ((h == 2'b01) ? 4'hF : 4'h0), "R5 control flags",
                        32'(ctl_flags), (h == 2'b01) ? 32'hF : 32'h0);
                    chk(lane_valid == good, "R6 lane valid", 32'(lane_valid), 32'(good));
                    chk(hdr_err == (j == 0 && !good), "R6 header error",
                        32'(hdr_err), 32'(j == 0 && !good));
                    idx++;
                end else if (c > al_c && !word_valid) begin
                    chk(blk_start == 4'h0 && !hdr_err, "R4 stall quiet",
                        {27'b0, hdr_err, blk_start}, 32'h0);
                end
                if (rate && word_valid) nv++;
                if (rate && c == 1) chk(!word_valid, "R9 first cycle", 32'(word_valid), 32'h0);
                if (rate && c == 2) chk(word_valid, "R9 second cycle", 32'(word_valid), 32'h1);
            end
            for (int i = 0; i < 32; i++) rx_bits[i] = sbits[c * 32 + i];
            align_load = (c == al_c);
            slip_ofs = 5'(slip);
        end
        align_load = 1'b0;
        if (rate) chk(nv == 64, "R4 valid count per 65 cycles", 32'(nv), 32'd64);
        chk(idx == nexp, "R1 all words delivered", 32'(idx), 32'(nexp));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        // R7, R9, R4, R1-R6: 16 blocks from reset, offset 0
        build(0, 16, 0);
        do_reset();
        run(65, -1, 0, 0, 64, 1'b1);
        // R8: realign at the first word with a 13-bit slip
        build(13, 4, 4);
        do_reset();
        run(17, 0, 13, 4, 16, 1'b0);
        // R8: garbage words, then realign mid-stream with a 5-bit slip
        build(101, 4, 8);
        do_reset();
        run(20, 3, 5, 8, 16, 1'b0);
        // R7: reset after traffic clears the outputs
        do_reset();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule